// File: doc/BRIEF.md
# Isochronous Video Packet Framer

The framer sits between a compressed-video byte FIFO and an isochronous IN endpoint. Each time the endpoint logic asks for a packet, the framer emits exactly one packet. The packet always has the full size chosen by the current alternate setting. It is one of three kinds.

- A header packet opens a frame and carries metadata about that frame.
- A drop packet is sent when too little data is buffered to fill a packet.
- An image packet starts with a rolling sequence byte and carries frame data. The last image packet of a frame is zero-padded to full size.

The padding length of the most recent image packet is reported in bytes 2 and 3 of later header and drop packets. This lets the receiver strip the padding.

The FIFO is show-ahead. The head byte carries two marker bits: frame start and frame end. The FIFO also gives a fill level, and a flag `frame_end_i` that is high while the last byte of the current frame is somewhere in the FIFO. The metadata inputs are sampled while the header packet is being sent. The output is a byte stream with valid and last strobes. There is no backpressure.

Top module: `iso_video_framer`

## Requirements
- R1: The maximum packet size M is taken from `alt_set_i` at the request. The mapping is 0→0, 1→128, 2→384, 3→512, 4→640, 5→768, 6→896 and 7→1023 bytes. An accepted request produces exactly M bytes:
  - `pkt_valid_o` is high on M consecutive cycles, starting the cycle after the request.
  - `pkt_last_o` is high only on the M-th byte.
  - `pkt_valid_o` is low in the cycle after the M-th byte.
- R2: Header packet layout, by byte index:
  - 0: 0xFF
  - 1: 0x01
  - 2 and 3: low and high byte of the reported padding count
  - 4: operation mode
  - 5: width
  - 6: height
  - 7: image mode
  - 8: quantisation table index
  - 9: frame count
  - 10: processing flags
  - 11: GPIO
  - 12: auxiliary GPIO
  - 13 up to M-1: zero

  A header packet pops no FIFO byte.
- R3: Outside a frame, a request yields a header packet only when the FIFO is non-empty and its head byte has the frame-start marker. Otherwise the request yields a drop packet. A header packet enters the frame state.
- R4: Drop packet layout: byte 0 is 0xFF, byte 1 is 0x00, bytes 2 and 3 are the reported padding count (low byte, then high byte), and all remaining bytes are zero. A drop packet pops nothing.
- R5: Inside a frame, a request yields an image packet when the FIFO level is at least M-1 or `frame_end_i` is high. Otherwise it yields a drop packet.
- R6: Byte 0 of an image packet is the sequence value. The header sets it to 0. It increments after each image packet and wraps from 0xFE to 0x00, so it never equals 0xFF.
- R7: Bytes 1 to M-1 of an image packet are FIFO bytes in FIFO order, one pop per byte. Popping stops after a byte with the frame-end marker, and the rest of the packet is zeros. That packet ends the frame. Its zero count becomes the reported padding count. An image packet that does not end a frame sets the reported count to 0. Header and drop packets leave the count unchanged.
- R8: The frame count is the number of frames whose last byte has been sent, modulo 256.
- R9: A request is ignored when `alt_set_i` is 0, and also while a packet is being sent.
- R10: After reset, no packet is in progress and the block is outside a frame. The sequence value, frame count and reported padding count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alt_set_i | input | 3 | Alternate setting selecting the packet size |
| op_mode_i | input | 8 | Operation mode metadata |
| img_width_i | input | 8 | Image width metadata |
| img_height_i | input | 8 | Image height metadata |
| img_mode_i | input | 8 | Image mode metadata |
| qtab_idx_i | input | 8 | Quantisation table index metadata |
| proc_flags_i | input | 8 | Processing flags metadata |
| gpio_i | input | 8 | GPIO state metadata |
| aux_gpio_i | input | 8 | Auxiliary GPIO state metadata |
| fifo_data_i | input | 8 | FIFO head byte |
| fifo_sof_i | input | 1 | Head byte is the first byte of a frame |
| fifo_eof_i | input | 1 | Head byte is the last byte of a frame |
| fifo_level_i | input | LVL_W | Number of bytes in the FIFO |
| frame_end_i | input | 1 | FIFO holds the last byte of the current frame |
| fifo_pop_o | output | 1 | Consume the head byte |
| pkt_req_i | input | 1 | Packet request strobe |
| pkt_data_o | output | 8 | Packet byte |
| pkt_valid_o | output | 1 | Packet byte valid |
| pkt_last_o | output | 1 | Final byte of the packet |

## Verification
Frame sizes are chosen so that each packet kind can be told apart from the others:
- A frame much longer than one packet gives full image packets followed by one short, padded final packet, which shows that the padding count is carried into the next drop or header.
- A frame shorter than one packet is admitted only through the frame-end flag.
- A partly loaded frame with no end marker has to produce an in-frame drop rather than an image packet.

A single frame of more than 256 image packets exposes the sequence wrap from 0xFE to 0x00. Random alternate settings, metadata and frame lengths then mix all three packet kinds and all eight sizes, including setting 0. Extra requests are pulsed in the middle of packets to show that they are ignored.

// File: rtl/iso_framer_pkg.sv
package iso_framer_pkg;
  localparam int SIZE_W = 10;

  typedef enum logic [1:0] {K_IDLE, K_HDR, K_DROP, K_IMG} kind_e;

  typedef struct packed {
    logic [7:0] op_mode;
    logic [7:0] width;
    logic [7:0] height;
    logic [7:0] img_mode;
    logic [7:0] qtab;
    logic [7:0] flags;
    logic [7:0] gpio;
    logic [7:0] aux_gpio;
  } meta_t;

  function automatic logic [SIZE_W-1:0] alt_to_size(input logic [2:0] alt);
    case (alt)
      3'd0:    return SIZE_W'(0);
      3'd1:    return SIZE_W'(128);
      3'd7:    return SIZE_W'(1023);
      default: return SIZE_W'(384 + 128 * (int'(alt) - 2));
    endcase
  endfunction
endpackage

// File: rtl/iso_pkt_size_lut.sv
module iso_pkt_size_lut
  import iso_framer_pkg::*;
#(
  parameter int SZ_W = SIZE_W
) (
  input  logic [2:0]      alt_i,
  output logic [SZ_W-1:0] size_o
);
  assign size_o = SZ_W'(alt_to_size(alt_i));
endmodule

// File: rtl/iso_pkt_sched.sv
module iso_pkt_sched
  import iso_framer_pkg::*;
#(
  parameter int LVL_W = 16,
  parameter int SZ_W  = SIZE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             busy_i,
  input  logic [SZ_W-1:0]  size_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             fifo_sof_i,
  input  logic             frame_end_i,
  input  logic             pkt_done_i,
  input  logic             eof_sent_i,
  input  logic [SZ_W-1:0]  new_pad_i,
  output logic             start_o,
  output kind_e            kind_o,
  output logic [SZ_W-1:0]  size_o,
  output logic [7:0]       seq_o,
  output logic [7:0]       frame_cnt_o,
  output logic [SZ_W-1:0]  pad_o
);
  localparam logic [7:0] SEQ_TOP = 8'hFE;

  logic             in_frame_q;
  kind_e            kind_q, kind_d;
  logic [SZ_W-1:0]  size_q, pad_q;
  logic [7:0]       seq_q, fcnt_q;
  logic [LVL_W-1:0] need;

  assign need = LVL_W'(size_i) - LVL_W'(1);

  always_comb begin
    if (!in_frame_q)
      kind_d = (fifo_level_i != '0 && fifo_sof_i) ? K_HDR : K_DROP;
    else
      kind_d = (fifo_level_i >= need || frame_end_i) ? K_IMG : K_DROP;
  end

  assign start_o = req_i && !busy_i && (size_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_frame_q <= 1'b0;
      kind_q     <= K_IDLE;
      size_q     <= '0;
      seq_q      <= '0;
      fcnt_q     <= '0;
      pad_q      <= '0;
    end else if (start_o) begin
      kind_q <= kind_d;
      size_q <= size_i;
      if (kind_d == K_HDR) begin
        in_frame_q <= 1'b1;
        seq_q      <= '0;
      end
    end else if (pkt_done_i && kind_q == K_IMG) begin
      seq_q <= (seq_q == SEQ_TOP) ? 8'h00 : seq_q + 8'd1;
      pad_q <= new_pad_i;
      if (eof_sent_i) begin
        in_frame_q <= 1'b0;
        fcnt_q     <= fcnt_q + 8'd1;
      end
    end
  end

  assign kind_o      = kind_q;
  assign size_o      = size_q;
  assign seq_o       = seq_q;
  assign frame_cnt_o = fcnt_q;
  assign pad_o       = pad_q;

  a_r6_seq_never_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_q != 8'hFF);
  a_r6_hdr_seq_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && kind_q == K_HDR) |-> (seq_q == 8'h00));
  a_r5_img_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && kind_q == K_IMG) |-> in_frame_q);
  a_r3_hdr_leaves_frame_open: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_done_i && kind_q == K_HDR) |=> in_frame_q);
endmodule

// File: rtl/iso_pkt_emitter.sv
module iso_pkt_emitter
  import iso_framer_pkg::*;
#(
  parameter int SZ_W = SIZE_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  kind_e           kind_i,
  input  logic [SZ_W-1:0] size_i,
  input  logic [7:0]      seq_i,
  input  logic [7:0]      frame_cnt_i,
  input  logic [SZ_W-1:0] pad_i,
  input  meta_t           meta_i,
  input  logic [7:0]      fifo_data_i,
  input  logic            fifo_eof_i,
  output logic            busy_o,
  output logic [7:0]      data_o,
  output logic            valid_o,
  output logic            last_o,
  output logic            pop_o,
  output logic            done_o,
  output logic            eof_sent_o,
  output logic [SZ_W-1:0] new_pad_o
);
  logic            active_q, ended_q;
  logic [SZ_W-1:0] idx_q, pad_acc_q;
  logic [15:0]     pad_rep;
  logic            in_head;
  logic            eof_pop;

  assign pad_rep = 16'(pad_i);
  assign in_head = (idx_q >> 4) == '0;
  assign valid_o = active_q;
  assign busy_o  = active_q;
  assign last_o  = active_q && (idx_q == size_i - SZ_W'(1));
  assign done_o  = last_o;
  assign pop_o   = active_q && kind_i == K_IMG && idx_q != '0 && !ended_q;
  assign eof_pop = pop_o && fifo_eof_i;
  assign eof_sent_o = ended_q || eof_pop;
  assign new_pad_o  = eof_pop ? '0 : pad_acc_q;

  always_comb begin
    data_o = 8'h00;
    if (active_q) begin
      unique case (kind_i)
        K_HDR: if (in_head) begin
          case (idx_q[3:0])
            4'd0:    data_o = 8'hFF;
            4'd1:    data_o = 8'h01;
            4'd2:    data_o = pad_rep[7:0];
            4'd3:    data_o = pad_rep[15:8];
            4'd4:    data_o = meta_i.op_mode;
            4'd5:    data_o = meta_i.width;
            4'd6:    data_o = meta_i.height;
            4'd7:    data_o = meta_i.img_mode;
            4'd8:    data_o = meta_i.qtab;
            4'd9:    data_o = frame_cnt_i;
            4'd10:   data_o = meta_i.flags;
            4'd11:   data_o = meta_i.gpio;
            4'd12:   data_o = meta_i.aux_gpio;
            default: data_o = 8'h00;
          endcase
        end
        K_DROP: if (in_head) begin
          case (idx_q[3:0])
            4'd0:    data_o = 8'hFF;
            4'd2:    data_o = pad_rep[7:0];
            4'd3:    data_o = pad_rep[15:8];
            default: data_o = 8'h00;
          endcase
        end
        K_IMG: begin
          if (idx_q == '0) data_o = seq_i;
          else if (pop_o)  data_o = fifo_data_i;
        end
        default: data_o = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      ended_q   <= 1'b0;
      idx_q     <= '0;
      pad_acc_q <= '0;
    end else if (start_i) begin
      active_q  <= 1'b1;
      ended_q   <= 1'b0;
      idx_q     <= '0;
      pad_acc_q <= '0;
    end else if (active_q) begin
      if (last_o) active_q <= 1'b0;
      else        idx_q    <= idx_q + SZ_W'(1);
      if (eof_pop) begin
        ended_q   <= 1'b1;
        pad_acc_q <= size_i - SZ_W'(1) - idx_q;
      end
    end
  end

  a_r1_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o) |=> valid_o);
  a_r1_gap_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> !valid_o);
  a_r7_stop_after_eof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_pop |=> !pop_o);
  a_r7_pad_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (new_pad_o < size_i));
endmodule

// File: rtl/iso_video_framer.sv
module iso_video_framer
  import iso_framer_pkg::*;
#(
  parameter int LVL_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       alt_set_i,
  input  logic [7:0]       op_mode_i,
  input  logic [7:0]       img_width_i,
  input  logic [7:0]       img_height_i,
  input  logic [7:0]       img_mode_i,
  input  logic [7:0]       qtab_idx_i,
  input  logic [7:0]       proc_flags_i,
  input  logic [7:0]       gpio_i,
  input  logic [7:0]       aux_gpio_i,
  input  logic [7:0]       fifo_data_i,
  input  logic             fifo_sof_i,
  input  logic             fifo_eof_i,
  input  logic [LVL_W-1:0] fifo_level_i,
  input  logic             frame_end_i,
  output logic             fifo_pop_o,
  input  logic             pkt_req_i,
  output logic [7:0]       pkt_data_o,
  output logic             pkt_valid_o,
  output logic             pkt_last_o
);
  localparam int SZ_W = SIZE_W;

  logic [SZ_W-1:0] req_size, cur_size, rep_pad, new_pad;
  logic            start, busy, done, eof_sent;
  kind_e           kind;
  logic [7:0]      seq, fcnt;
  meta_t           meta;

  assign meta = '{op_mode: op_mode_i, width: img_width_i, height: img_height_i,
                  img_mode: img_mode_i, qtab: qtab_idx_i, flags: proc_flags_i,
                  gpio: gpio_i, aux_gpio: aux_gpio_i};

  iso_pkt_size_lut #(.SZ_W(SZ_W)) u_lut (
    .alt_i  (alt_set_i),
    .size_o (req_size)
  );

  iso_pkt_sched #(.LVL_W(LVL_W), .SZ_W(SZ_W)) u_sched (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (pkt_req_i),
    .busy_i       (busy),
    .size_i       (req_size),
    .fifo_level_i (fifo_level_i),
    .fifo_sof_i   (fifo_sof_i),
    .frame_end_i  (frame_end_i),
    .pkt_done_i   (done),
    .eof_sent_i   (eof_sent),
    .new_pad_i    (new_pad),
    .start_o      (start),
    .kind_o       (kind),
    .size_o       (cur_size),
    .seq_o        (seq),
    .frame_cnt_o  (fcnt),
    .pad_o        (rep_pad)
  );

  iso_pkt_emitter #(.SZ_W(SZ_W)) u_emit (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start),
    .kind_i      (kind),
    .size_i      (cur_size),
    .seq_i       (seq),
    .frame_cnt_i (fcnt),
    .pad_i       (rep_pad),
    .meta_i      (meta),
    .fifo_data_i (fifo_data_i),
    .fifo_eof_i  (fifo_eof_i),
    .busy_o      (busy),
    .data_o      (pkt_data_o),
    .valid_o     (pkt_valid_o),
    .last_o      (pkt_last_o),
    .pop_o       (fifo_pop_o),
    .done_o      (done),
    .eof_sent_o  (eof_sent),
    .new_pad_o   (new_pad)
  );

  a_r9_start_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pkt_valid_o) |-> ($past(pkt_req_i) && $past(alt_set_i) != 3'd0));
  a_r7_pop_in_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> pkt_valid_o);
endmodule

// File: tb/iso_video_framer_bench.sv
module iso_video_framer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LVL_W = 16;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [2:0] alt = '0;
  logic [7:0] m_op = 0, m_w = 0, m_h = 0, m_im = 0, m_q = 0, m_fl = 0, m_g = 0, m_ag = 0;
  logic [7:0] f_data = 0;
  logic f_sof = 0, f_eof = 0, f_end = 0, req = 0;
  logic [LVL_W-1:0] f_level = '0;
  logic pop, valid, last;
  logic [7:0] dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_video_framer #(.LVL_W(LVL_W)) u_iso_video_framer (
    .clk_i(clk), .rst_ni(rst_n), .alt_set_i(alt),
    .op_mode_i(m_op), .img_width_i(m_w), .img_height_i(m_h), .img_mode_i(m_im),
    .qtab_idx_i(m_q), .proc_flags_i(m_fl), .gpio_i(m_g), .aux_gpio_i(m_ag),
    .fifo_data_i(f_data), .fifo_sof_i(f_sof), .fifo_eof_i(f_eof),
    .fifo_level_i(f_level), .frame_end_i(f_end), .fifo_pop_o(pop),
    .pkt_req_i(req), .pkt_data_o(dout), .pkt_valid_o(valid), .pkt_last_o(last));

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [9:0] q[$];
  int eofs = 0;
  // bench model state
  bit b_in_frame = 0;
  int b_seq = 0, b_frames = 0, b_pad = 0;
  logic [7:0] exp_b[1024];
  logic [7:0] cap[1100];
  logic [7:0] last_byte0;

  function automatic int size_of(input logic [2:0] a);
    case (a)
      3'd0: return 0;
      3'd1: return 128;
      3'd7: return 1023;
      default: return 384 + 128 * (int'(a) - 2);
    endcase
  endfunction

  task automatic check(input bit ok, input string req_tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  task automatic drive_fifo();
    f_level = LVL_W'(q.size());
    f_end   = (eofs > 0);
    if (q.size() > 0) begin
      f_data = q[0][7:0]; f_eof = q[0][8]; f_sof = q[0][9];
    end else begin
      f_data = 0; f_eof = 0; f_sof = 0;
    end
  endtask

  task automatic push_bytes(input int n, input bit sof_first, input bit eof_last);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'($urandom);
      bit s = sof_first && i == 0;
      bit e = eof_last && i == n - 1;
      q.push_back({s, e, b});
      if (e) eofs++;
    end
    drive_fifo();
  endtask

  task automatic rand_meta();
    m_op = 8'($urandom); m_w = 8'($urandom); m_h = 8'($urandom); m_im = 8'($urandom);
    m_q = 8'($urandom); m_fl = 8'($urandom); m_g = 8'($urandom); m_ag = 8'($urandom);
  endtask

  // Invariant: tasks start and end at posedge + 1.
  task automatic run_packet(input logic [2:0] a, input bit extra);
    int m, kind, k, np, got, lastpos, mism, first_bad, pre, tag_i;
    bit ended, pend;
    string tg;
    m = size_of(a);
    alt = a;
    if (m == 0) begin
      req = 1;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        check(!valid && !pop, "R9", "alt 0 valid", int'(valid), 0);
        @(posedge clk); #1; req = 0;
      end
      return;
    end
    if (!b_in_frame) kind = (q.size() > 0 && q[0][9]) ? 1 : 2;
    else kind = (q.size() >= m - 1 || eofs > 0) ? 3 : 2;
    tg = (kind == 1) ? "R2 R3" : (kind == 2) ? "R4 R5" : "R6 R7";
    for (int i = 0; i < m; i++) exp_b[i] = 0;
    k = 0; np = 0; ended = 0;
    if (kind != 3) begin
      exp_b[0] = 8'hFF; exp_b[1] = (kind == 1) ? 8'h01 : 8'h00;
      exp_b[2] = 8'(b_pad); exp_b[3] = 8'(b_pad >> 8);
      if (kind == 1) begin
        exp_b[4] = m_op; exp_b[5] = m_w; exp_b[6] = m_h; exp_b[7] = m_im; exp_b[8] = m_q;
        exp_b[9] = 8'(b_frames); exp_b[10] = m_fl; exp_b[11] = m_g; exp_b[12] = m_ag;
      end
    end else begin
      exp_b[0] = 8'(b_seq);
      for (int i = 1; i < m; i++) begin
        if (!ended) begin
          exp_b[i] = q[k][7:0];
          if (q[k][8]) begin ended = 1; np = m - 1 - i; end
          k++;
        end
      end
    end
    pre = q.size();
    req = 1;
    @(posedge clk); #1; req = 0;
    got = 0; lastpos = -1;
    while (got < 1100) begin
      @(negedge clk);
      if (!valid) break;
      cap[got] = dout;
      if (last) lastpos = (lastpos < 0) ? got : -2;
      got++;
      pend = pop;
      @(posedge clk); #1;
      if (pend) begin
        if (q[0][8]) eofs--;
        void'(q.pop_front());
        drive_fifo();
      end
      req = (extra && got == 3);
    end
    @(posedge clk); #1; req = 0;
    tag_i = 0;
    check(got == m, extra ? "R1 R9" : "R1", "packet length", got, m);
    check(lastpos == m - 1, "R1", "last position", lastpos, m - 1);
    mism = 0; first_bad = -1;
    for (int i = 0; i < m && i < got; i++)
      if (cap[i] !== exp_b[i]) begin mism++; if (first_bad < 0) first_bad = i; end
    if (first_bad >= 0)
      check(0, tg, $sformatf("byte %0d", first_bad), int'(cap[first_bad]), int'(exp_b[first_bad]));
    else check(1, tg, "bytes", 0, 0);
    check(q.size() == pre - k, "R7", "bytes popped", pre - q.size(), k);
    last_byte0 = cap[0];
    if (kind == 1) begin b_in_frame = 1; b_seq = 0; end
    if (kind == 3) begin
      b_seq = (b_seq == 254) ? 0 : b_seq + 1;
      b_pad = ended ? np : 0;
      if (ended) begin b_in_frame = 0; b_frames = (b_frames + 1) % 256; end
    end
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual %0d expected %0d", WATCHDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2718));
    drive_fifo();
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check(!valid && !pop && !last, "R10", "outputs in reset", int'(valid), 0);
    rst_n = 1;
    @(posedge clk); #1;
    check(!valid, "R10", "idle after reset", int'(valid), 0);
    // R9: alt 0 ignored
    run_packet(3'd0, 0);
    // R3 R4 R10: empty FIFO outside frame gives drop with zero pad
    run_packet(3'd2, 0);
    // frame longer than a packet: header, two full, one padded image packet
    push_bytes(300, 1, 1);
    rand_meta();
    run_packet(3'd1, 1);
    run_packet(3'd1, 0);
    run_packet(3'd1, 1);
    run_packet(3'd1, 0);
    check(b_pad == 81, "R7", "model pad after short tail", b_pad, 81);
    // R7: drop reports pad of the last image packet
    run_packet(3'd1, 0);
    check(cap[2] == 8'd81 && cap[3] == 8'd0, "R7", "drop pad byte", int'(cap[2]), 81);
    // R5: partial frame without end marker gives in-frame drop
    push_bytes(100, 1, 0);
    rand_meta();
    run_packet(3'd3, 0);
    run_packet(3'd1, 0);
    check(cap[0] == 8'hFF && cap[1] == 8'h00, "R5", "in-frame drop tag", int'(cap[1]), 0);
    push_bytes(200, 0, 1);
    run_packet(3'd1, 0);
    run_packet(3'd1, 0);
    run_packet(3'd1, 0);
    // frame shorter than one packet, admitted by frame-end flag; R8 frame count
    push_bytes(1, 1, 1);
    rand_meta();
    run_packet(3'd7, 0);
    check(cap[9] == 8'd2, "R8", "frame count", int'(cap[9]), 2);
    run_packet(3'd7, 0);
    check(cap[0] == 8'h00, "R6", "seq after header", int'(cap[0]), 0);
    // R6: sequence wrap in one long frame
    push_bytes(127 * 257 + 5, 1, 1);
    run_packet(3'd1, 0);
    for (int n = 1; n <= 258; n++) begin
      run_packet(3'd1, 0);
      if (n == 255) check(last_byte0 == 8'hFE, "R6", "seq top", int'(last_byte0), 254);
      if (n == 256) check(last_byte0 == 8'h00, "R6", "seq wrap", int'(last_byte0), 0);
    end
    // random mix
    for (int it = 0; it < 60; it++) begin
      if (q.size() < 1500 && ($urandom % 3) == 0) push_bytes(1 + int'($urandom % 1500), 1, 1);
      rand_meta();
      run_packet(($urandom % 8 == 0) ? 3'd0 : 3'(1 + $urandom % 7), ($urandom % 4) == 0);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule